// File: doc/BRIEF.md
# Multidrop Address-Filtered Serial Receiver

This block receives asynchronous serial frames from a line shared by several nodes. The line rests high. Each frame opens with a low start bit and carries eight data bits, least significant bit first. It closes with a stop bit that must be high. A 16x sampling enable drives the receiver. It confirms a start bit at the middle of that bit and then takes every later bit at its centre. Received bytes go into a holding register, and a ready flag marks a byte as waiting. A receive interrupt follows the ready flag. An error interrupt follows the framing and overrun flags.

With `mpMode` high, each frame carries one more bit between the last data bit and the stop bit. A 1 in that bit marks the frame as an address frame, and a 0 marks it as a payload frame. After reset the receiver is not addressed and drops every payload frame. When an address frame carries a value equal to `localId`, the receiver becomes addressed and delivers that value, tagged as an address. It then passes the payload frames that follow. An address frame with any other value returns it to dropping payload frames. With `mpMode` low, frames have no extra bit and every good byte is delivered.

Top module: `multidropRx`

## Requirements
- R1: A low pulse on `rxLine` shorter than half a bit time is not taken as a start bit. No flag changes and no byte is delivered.
- R2: With `mpMode`=0, a frame is a 0 start bit, then D0 to D7, then a 1 stop bit. The byte appears on `rxData` with `rxReady`=1, `rxIrq`=1 and `rxIsAddr`=0.
- R3: A stop bit sampled as 0 sets `frameErr` and `errIrq`, and the byte is not delivered.
- R4: A pulse on `readStrobe` clears `rxReady` and `rxIrq` on the next clock.
- R5: With `mpMode`=1, a frame is a 0 start bit, then D0 to D7, then the address bit, then a 1 stop bit. While not addressed, frames whose address bit is 0 are dropped and `rxReady` stays 0.
- R6: An address frame (address bit 1) whose data equals `localId` sets `addressed` and is delivered with `rxIsAddr`=1.
- R7: While addressed, payload frames are delivered with `rxIsAddr`=0.
- R8: An address frame whose data differs from `localId` clears `addressed`, is not delivered, and the payload frames after it are dropped.
- R9: A byte accepted while `rxReady` is still 1 sets `overrun` and `errIrq`. That byte is discarded and `rxData` keeps the earlier byte.
- R10: A pulse on `errAck` clears `frameErr` and `overrun`.
- R11: A synchronous high `rst` clears every flag and `addressed`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleTick | input | 1 | Enable at 16 times the bit rate |
| rxLine | input | 1 | Serial input, idle high |
| mpMode | input | 1 | 1 = frames carry an address bit |
| localId | input | 8 | Address of this node |
| readStrobe | input | 1 | Byte taken; clears the ready flag |
| errAck | input | 1 | Clears the framing and overrun flags |
| rxData | output | 8 | Last delivered byte |
| rxIsAddr | output | 1 | Delivered byte came from an address frame |
| rxReady | output | 1 | A byte is waiting |
| frameErr | output | 1 | Stop bit was sampled low |
| overrun | output | 1 | A byte was lost because the ready flag was still set |
| addressed | output | 1 | The last address frame matched `localId` |
| rxIrq | output | 1 | Receive interrupt request |
| errIrq | output | 1 | Error interrupt request |

## Verification
Frame results are registered one clock after the stop-bit centre, and that centre lags the line by the two-stage input synchronizer. A frame's flags are therefore due about half a bit before the stop bit ends on the wire. The bench samples only after the stop bit and one further idle bit have been driven, so each result has settled with margin. The effects of `readStrobe`, `errAck` and `rst` are due on the next clock, and the bench samples them one full cycle after the pulse, at a falling edge.

// File: rtl/mpRxPkg.sv
package mpRxPkg;
  typedef enum logic [1:0] {
    S_IDLE,
    S_START,
    S_BITS,
    S_STOP
  } rxState_e;

  typedef struct packed {
    logic shiftEn;  // capture one data/address bit
    logic finish;   // stop-bit centre reached
  } rxStrobe_t;
endpackage

// File: rtl/mpRxCtrl.sv
module mpRxCtrl
  import mpRxPkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      sampleTick,
  input  logic      lineSync,
  input  logic      mpMode,
  output rxStrobe_t strobe
);
  localparam int HALF  = OVERSAMPLE / 2;
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int BIT_W = $clog2(DATA_W + 2);

  rxState_e         state;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitIdx;
  logic [BIT_W-1:0] lastBit;
  logic             fullBit;
  logic             halfBit;

  always_comb begin
    lastBit = mpMode ? BIT_W'(DATA_W) : BIT_W'(DATA_W - 1);
    fullBit = (cnt == CNT_W'(OVERSAMPLE - 1));
    halfBit = (cnt == CNT_W'(HALF - 1));
    strobe.shiftEn = sampleTick && (state == S_BITS) && fullBit;
    strobe.finish  = sampleTick && (state == S_STOP) && fullBit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else if (sampleTick) begin
      case (state)
        S_IDLE: begin
          if (!lineSync) begin
            state <= S_START;
            cnt   <= '0;
          end
        end
        S_START: begin
          if (halfBit) begin
            cnt    <= '0;
            bitIdx <= '0;
            state  <= lineSync ? S_IDLE : S_BITS;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_BITS: begin
          if (fullBit) begin
            cnt <= '0;
            if (bitIdx == lastBit) state <= S_STOP;
            else bitIdx <= bitIdx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STOP: begin
          if (fullBit) begin
            cnt   <= '0;
            state <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2: sampling only advances on the oversampling enable
  p_tick_gate_r2: assert property (@(posedge clk) disable iff (rst)
    !sampleTick |=> $stable(state));

  // R1: a line back high at the half-bit check abandons the frame
  p_glitch_drop_r1: assert property (@(posedge clk) disable iff (rst)
    (sampleTick && state == S_START && halfBit && lineSync) |=> (state == S_IDLE));
endmodule

// File: rtl/mpRxData.sv
module mpRxData
  import mpRxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxLine,
  input  rxStrobe_t         strobe,
  input  logic              mpMode,
  input  logic [DATA_W-1:0] localId,
  input  logic              readStrobe,
  input  logic              errAck,
  output logic              lineSync,
  output logic [DATA_W-1:0] rxData,
  output logic              rxIsAddr,
  output logic              rxReady,
  output logic              frameErr,
  output logic              overrun,
  output logic              addressed
);
  logic              syncA;
  logic [DATA_W:0]   shiftReg;
  logic [DATA_W-1:0] wordData;
  logic              mpBit;
  logic              deliver;
  logic              fromAddr;
  logic              addrSet;
  logic              addrClr;
  logic              badStop;
  logic              slotFree;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncA    <= 1'b1;
      lineSync <= 1'b1;
    end else begin
      syncA    <= rxLine;
      lineSync <= syncA;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) shiftReg <= '0;
    else if (strobe.shiftEn) shiftReg <= {lineSync, shiftReg[DATA_W:1]};
  end

  always_comb begin
    wordData = mpMode ? shiftReg[DATA_W-1:0] : shiftReg[DATA_W:1];
    mpBit    = mpMode && shiftReg[DATA_W];
    deliver  = 1'b0;
    fromAddr = 1'b0;
    addrSet  = 1'b0;
    addrClr  = 1'b0;
    badStop  = 1'b0;
    if (strobe.finish) begin
      if (!lineSync) begin
        badStop = 1'b1;
      end else if (!mpMode) begin
        deliver = 1'b1;
      end else if (mpBit) begin
        if (wordData == localId) begin
          addrSet  = 1'b1;
          deliver  = 1'b1;
          fromAddr = 1'b1;
        end else begin
          addrClr = 1'b1;
        end
      end else if (addressed) begin
        deliver = 1'b1;
      end
    end
    slotFree = !rxReady || readStrobe;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxData    <= '0;
      rxIsAddr  <= 1'b0;
      rxReady   <= 1'b0;
      frameErr  <= 1'b0;
      overrun   <= 1'b0;
      addressed <= 1'b0;
    end else begin
      if (deliver && slotFree) begin
        rxData   <= wordData;
        rxIsAddr <= fromAddr;
        rxReady  <= 1'b1;
      end else if (readStrobe) begin
        rxReady <= 1'b0;
      end

      if (deliver && !slotFree) overrun <= 1'b1;
      else if (errAck) overrun <= 1'b0;

      if (badStop) frameErr <= 1'b1;
      else if (errAck) frameErr <= 1'b0;

      if (addrSet) addressed <= 1'b1;
      else if (addrClr) addressed <= 1'b0;
    end
  end

  // R3: a low stop bit raises the framing flag
  p_bad_stop_r3: assert property (@(posedge clk) disable iff (rst)
    (strobe.finish && !lineSync) |=> frameErr);

  // R4: taking the byte empties the holding register
  p_read_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (readStrobe && !strobe.finish) |=> !rxReady);

  // R9: an overrun leaves the held byte untouched
  p_overrun_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (strobe.finish && rxReady && !readStrobe) |=> $stable(rxData));

  // R10: acknowledge clears both error flags when no frame ends
  p_err_ack_r10: assert property (@(posedge clk) disable iff (rst)
    (errAck && !strobe.finish) |=> (!frameErr && !overrun));

  // R8: the addressed state moves only at the end of a frame
  p_addr_at_frame_end_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(addressed) |-> $past(strobe.finish));

  // R5: a payload frame seen while not addressed leaves the ready flag alone
  p_skip_unaddressed_r5: assert property (@(posedge clk) disable iff (rst)
    (strobe.finish && mpMode && !addressed && !shiftReg[DATA_W] && !readStrobe)
      |=> $stable(rxReady));
endmodule

// File: rtl/multidropRx.sv
module multidropRx
  import mpRxPkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sampleTick,
  input  logic              rxLine,
  input  logic              mpMode,
  input  logic [DATA_W-1:0] localId,
  input  logic              readStrobe,
  input  logic              errAck,
  output logic [DATA_W-1:0] rxData,
  output logic              rxIsAddr,
  output logic              rxReady,
  output logic              frameErr,
  output logic              overrun,
  output logic              addressed,
  output logic              rxIrq,
  output logic              errIrq
);
  rxStrobe_t strobe;
  logic      lineSync;

  mpRxCtrl #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .sampleTick (sampleTick),
    .lineSync   (lineSync),
    .mpMode     (mpMode),
    .strobe     (strobe)
  );

  mpRxData #(.DATA_W(DATA_W)) u_data (
    .clk        (clk),
    .rst        (rst),
    .rxLine     (rxLine),
    .strobe     (strobe),
    .mpMode     (mpMode),
    .localId    (localId),
    .readStrobe (readStrobe),
    .errAck     (errAck),
    .lineSync   (lineSync),
    .rxData     (rxData),
    .rxIsAddr   (rxIsAddr),
    .rxReady    (rxReady),
    .frameErr   (frameErr),
    .overrun    (overrun),
    .addressed  (addressed)
  );

  assign rxIrq  = rxReady;
  assign errIrq = frameErr || overrun;
endmodule

// File: tb/multidropRx_bench.sv
module multidropRx_bench;
  localparam int OS = 16;
  localparam logic [7:0] MY_ID = 8'h5A;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sampleTick = 1'b1;
  logic       rxLine = 1'b1;
  logic       mpMode = 1'b0;
  logic [7:0] localId = MY_ID;
  logic       readStrobe = 1'b0;
  logic       errAck = 1'b0;
  logic [7:0] rxData;
  logic       rxIsAddr, rxReady, frameErr, overrun, addressed, rxIrq, errIrq;

  int checks = 0;
  int errors = 0;
  int tickDiv = 1;
  int tickCnt = 0;
  bit finished = 1'b0;

  multidropRx u_multidropRx (
    .clk(clk), .rst(rst), .sampleTick(sampleTick), .rxLine(rxLine),
    .mpMode(mpMode), .localId(localId), .readStrobe(readStrobe), .errAck(errAck),
    .rxData(rxData), .rxIsAddr(rxIsAddr), .rxReady(rxReady), .frameErr(frameErr),
    .overrun(overrun), .addressed(addressed), .rxIrq(rxIrq), .errIrq(errIrq)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (tickCnt >= tickDiv - 1) begin
      tickCnt    <= 0;
      sampleTick <= 1'b1;
    end else begin
      tickCnt    <= tickCnt + 1;
      sampleTick <= 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bitWait();
    repeat (OS * tickDiv) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input bit withMp, input bit mpv, input bit stopv);
    rxLine = 1'b0;
    bitWait();
    for (int i = 0; i < 8; i++) begin
      rxLine = d[i];
      bitWait();
    end
    if (withMp) begin
      rxLine = mpv;
      bitWait();
    end
    rxLine = stopv;
    bitWait();
    rxLine = 1'b1;
    bitWait();
  endtask

  task automatic doRead();
    @(negedge clk) readStrobe = 1'b1;
    @(negedge clk) readStrobe = 1'b0;
  endtask

  task automatic doAck();
    @(negedge clk) errAck = 1'b1;
    @(negedge clk) errAck = 1'b0;
  endtask

  task automatic pulseReset();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic checkCleared(input string tag);
    chk({tag, " rxReady"}, rxReady, 0);
    chk({tag, " frameErr"}, frameErr, 0);
    chk({tag, " overrun"}, overrun, 0);
    chk({tag, " addressed"}, addressed, 0);
    chk({tag, " rxIrq"}, rxIrq, 0);
    chk({tag, " errIrq"}, errIrq, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checkCleared("R11 after reset");

    // R1: a short low pulse is rejected
    rxLine = 1'b0;
    repeat (6) @(negedge clk);
    rxLine = 1'b1;
    repeat (200) @(negedge clk);
    chk("R1 glitch rxReady", rxReady, 0);
    chk("R1 glitch frameErr", frameErr, 0);

    // R2 and R4: all byte values, plain format
    for (int b = 0; b < 256; b++) begin
      sendFrame(8'(b), 1'b0, 1'b0, 1'b1);
      chk("R2 data", rxData, b);
      chk("R2 ready", rxReady, 1);
      chk("R2 irq", rxIrq, 1);
      chk("R2 isAddr", rxIsAddr, 0);
      doRead();
      chk("R4 ready cleared", rxReady, 0);
      chk("R4 irq cleared", rxIrq, 0);
    end

    // R2 with a sparse sampling enable
    tickDiv = 2;
    repeat (4) @(negedge clk);
    sendFrame(8'hC3, 1'b0, 1'b0, 1'b1);
    chk("R2 slow tick data", rxData, 8'hC3);
    chk("R2 slow tick ready", rxReady, 1);
    doRead();
    tickDiv = 1;
    repeat (4) @(negedge clk);

    // R3 and R10: bad stop bit
    sendFrame(8'h77, 1'b0, 1'b0, 1'b0);
    chk("R3 frameErr", frameErr, 1);
    chk("R3 errIrq", errIrq, 1);
    chk("R3 not delivered", rxReady, 0);
    doAck();
    chk("R10 frameErr cleared", frameErr, 0);
    chk("R10 errIrq cleared", errIrq, 0);

    // R9 and R10: overrun
    sendFrame(8'h11, 1'b0, 1'b0, 1'b1);
    sendFrame(8'h22, 1'b0, 1'b0, 1'b1);
    chk("R9 overrun", overrun, 1);
    chk("R9 errIrq", errIrq, 1);
    chk("R9 data kept", rxData, 8'h11);
    chk("R9 ready kept", rxReady, 1);
    doRead();
    doAck();
    chk("R10 overrun cleared", overrun, 0);

    // R5: not addressed after reset, payload dropped
    mpMode = 1'b1;
    sendFrame(8'h33, 1'b1, 1'b0, 1'b1);
    chk("R5 payload dropped", rxReady, 0);
    chk("R5 not addressed", addressed, 0);

    // R6, R7, R8: sweep of address values
    for (int i = 0; i < 64; i++) begin
      logic [7:0] id;
      logic [7:0] pay;
      id  = 8'(i * 4 + 2);
      pay = ~id;
      sendFrame(id, 1'b1, 1'b1, 1'b1);
      if (id == MY_ID) begin
        chk("R6 addressed", addressed, 1);
        chk("R6 ready", rxReady, 1);
        chk("R6 data", rxData, id);
        chk("R6 isAddr", rxIsAddr, 1);
        doRead();
      end else begin
        chk("R8 not addressed", addressed, 0);
        chk("R8 id dropped", rxReady, 0);
      end
      sendFrame(pay, 1'b1, 1'b0, 1'b1);
      if (id == MY_ID) begin
        chk("R7 ready", rxReady, 1);
        chk("R7 data", rxData, pay);
        chk("R7 isAddr", rxIsAddr, 0);
        doRead();
      end else begin
        chk("R8 payload dropped", rxReady, 0);
      end
    end

    // R11: reset from a busy state
    sendFrame(MY_ID, 1'b1, 1'b1, 1'b1);
    sendFrame(8'h44, 1'b1, 1'b0, 1'b0);
    chk("R11 pre addressed", addressed, 1);
    chk("R11 pre frameErr", frameErr, 1);
    pulseReset();
    checkCleared("R11 after busy reset");
    sendFrame(8'h55, 1'b1, 1'b0, 1'b1);
    chk("R11 payload dropped after reset", rxReady, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule